// File: doc/BRIEF.md
# Lock-Protected Peripheral Reset Bank

This block drives one reset pulse line for each peripheral slot on a chip. There are five banks of 32 slots each, so 160 lines in total. Software starts a reset by writing a mask into one of five reset-request registers. Each 1 bit in the mask starts a fixed-length pulse on the matching line. Once the pulse has run its length, the request bit clears by itself. No clear write is needed.

The request registers are guarded by a key register. Writing one exact 32-bit key opens the bank. Any other value written to the key register closes it. While the bank is closed, writes to the request registers are dropped and have no side effect. Software normally opens the bank, writes one or more masks, and then closes the bank again.

Slot `32*k + b` is selected by bit `b` of the request register for bank `k`. This matches a peripheral identifier whose bits 4:0 give the bit position and whose upper bits give the bank. Reading a request register returns the slots of that bank whose pulses are still running.

Top module: `periph_reset_bank`

## Requirements
- R1: After reset every line of `periph_rst` is low, the bank is closed, and reads of the key register and of every request register return zero.
- R2: A write of exactly 0xA6382D4C to offset 0x84 opens the bank from the next cycle. While the bank is open, a read of offset 0x84 returns 1 in bit 0 and zeros elsewhere.
- R3: A write of any other value to offset 0x84 closes the bank from the next cycle. This includes 0xA6382D4D and any value one bit away from the key.
- R4: While the bank is closed, writes to offsets 0x70, 0x74, 0x78, 0x7C and 0x80 start no pulse and change no read value.
- R5: While the bank is open, a write to offset 0x70+4k starts a pulse on `periph_rst[32k+b]` for every bit b that is 1 in the written data. Several bits may be set in one write. Bits written as 0 leave their slots unchanged.
- R6: A pulse is high for exactly PULSE_LEN cycles (default 4), starting in the cycle after the write. It then drops with no further write.
- R7: Writing 1 again to a slot whose pulse is still running restarts that pulse at its full length.
- R8: A read of offset 0x70+4k returns the running pulses of bank k. A read of any address that is neither a request register nor the key register returns zero. Writes to such addresses change neither the lock state nor any pulse.
- R9: An open bank stays open across any number of request writes until the key register is written with a value other than the key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| periph_rst | output | 160 | Active-high reset pulse, one line per peripheral slot |

## Verification
A lock flop stuck in the wrong state shows up on the next request write. If it is wrongly closed, the expected pulse is missing in the first cycle after the write. If it is wrongly open, a line rises that should have stayed low. A read of the key register shows the lock state in the same cycle without touching any output.

A pulse counter that is loaded with the wrong value, or that fails to count down, shows up as a line that is high for the wrong number of cycles. Sampling each line in every cycle from the write to the drop catches this within PULSE_LEN+1 cycles. A decode error that steers a mask to the wrong bank shows up at once, because the pulse appears on the wrong 32-bit group of `periph_rst`.

// File: rtl/rstbank_pkg.sv
// Shared constants and types for the peripheral reset bank.
// Assumes a byte-addressed register space with 32-bit aligned registers.
package rstbank_pkg;
    localparam int          NUM_BANKS   = 5;
    localparam int          BANK_W      = 32;
    localparam int          DATA_W      = 32;
    localparam int          ADDR_W      = 8;
    localparam int          REQ_BASE    = 'h70;
    localparam int          KEY_OFS     = 'h84;
    localparam logic [31:0] OPEN_KEY    = 32'hA6382D4C;
    localparam int          PULSE_LEN   = 4;
    localparam int          SLOTS       = NUM_BANKS * BANK_W;

    typedef enum logic {
        GUARD_CLOSED = 1'b0,
        GUARD_OPEN   = 1'b1
    } guard_state_e;
endpackage

// File: rtl/rstbank_guard.sv
// Key register of the reset bank. It holds the open/closed state.
// Assumes key_we pulses for one cycle for each bus write to the key offset.
module rstbank_guard
    import rstbank_pkg::*;
#(
    parameter int          KEY_W = DATA_W,
    parameter logic [31:0] KEY   = OPEN_KEY
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             key_we,
    input  logic [KEY_W-1:0] key_wdata,
    output logic             is_open
);
    guard_state_e state_q;

    // Open on an exact key match, close on any other value written here.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= GUARD_CLOSED;
        else if (key_we)
            state_q <= (key_wdata == KEY[KEY_W-1:0]) ? GUARD_OPEN : GUARD_CLOSED;
    end

    assign is_open = (state_q == GUARD_OPEN);

    a_r2_key_opens: assert property (@(posedge clk) disable iff (!rst_n)
        (key_we && key_wdata == KEY[KEY_W-1:0]) |=> is_open);
    a_r3_other_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (key_we && key_wdata != KEY[KEY_W-1:0]) |=> !is_open);
    a_r9_state_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !key_we |=> $stable(is_open));
endmodule

// File: rtl/rstbank_decode.sv
// Address decode for the request registers and the key register.
// Assumes the request registers are contiguous, four bytes apart.
module rstbank_decode
    import rstbank_pkg::*;
#(
    parameter int AW    = ADDR_W,
    parameter int NB    = NUM_BANKS,
    parameter int BASE  = REQ_BASE,
    parameter int KOFS  = KEY_OFS
) (
    input  logic [AW-1:0] addr,
    input  logic          we,
    output logic [NB-1:0] bank_hit,
    output logic [NB-1:0] bank_we,
    output logic          key_hit,
    output logic          key_we
);
    // Match the address against each request register offset.
    always_comb begin
        for (int k = 0; k < NB; k++)
            bank_hit[k] = (int'(addr) == BASE + 4 * k);
    end

    assign bank_we = bank_hit & {NB{we}};
    assign key_hit = (int'(addr) == KOFS);
    assign key_we  = key_hit & we;
endmodule

// File: rtl/rstbank_lane.sv
// One bank of pulse generators. Each slot has a down-counter that is loaded
// to LEN on a request and drives its line while it is not zero.
// Assumes load_en is already qualified by the open state of the guard.
module rstbank_lane
    import rstbank_pkg::*;
#(
    parameter int W   = BANK_W,
    parameter int LEN = PULSE_LEN
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_en,
    input  logic [W-1:0] load_bits,
    output logic [W-1:0] pulse
);
    localparam int CNT_W = $clog2(LEN + 1);

    logic [W-1:0] load_req;
    assign load_req = load_en ? load_bits : '0;

    for (genvar i = 0; i < W; i++) begin : g_slot
        logic [CNT_W-1:0] cnt_q;

        // Reload on a request, otherwise count down to zero.
        always_ff @(posedge clk) begin
            if (!rst_n)
                cnt_q <= '0;
            else if (load_req[i])
                cnt_q <= CNT_W'(LEN);
            else if (cnt_q != '0)
                cnt_q <= cnt_q - 1'b1;
        end

        assign pulse[i] = (cnt_q != '0);

        a_r6_drops_after_last: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt_q == CNT_W'(1) && !load_req[i]) |=> !pulse[i]);
        a_r7_restart_full: assert property (@(posedge clk) disable iff (!rst_n)
            load_req[i] |=> (pulse[i] && cnt_q == CNT_W'(LEN)));
    end

    a_r5_no_unrequested_start: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pulse & ~$past(pulse) & ~$past(load_req)) == '0));
endmodule

// File: rtl/periph_reset_bank.sv
// Top of the lock-protected peripheral reset bank. It joins the decode, the
// key guard and one pulse lane per bank, and muxes the read data.
// Assumes single-cycle writes and a combinational read path.
module periph_reset_bank
    import rstbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [SLOTS-1:0]  periph_rst
);
    logic [NUM_BANKS-1:0]             bank_hit;
    logic [NUM_BANKS-1:0]             bank_we;
    logic                             key_hit;
    logic                             key_we;
    logic                             is_open;
    logic [NUM_BANKS-1:0][BANK_W-1:0] lane_pulse;

    rstbank_decode u_decode (
        .addr     (bus_addr),
        .we       (bus_we),
        .bank_hit (bank_hit),
        .bank_we  (bank_we),
        .key_hit  (key_hit),
        .key_we   (key_we)
    );

    rstbank_guard u_guard (
        .clk       (clk),
        .rst_n     (rst_n),
        .key_we    (key_we),
        .key_wdata (bus_wdata),
        .is_open   (is_open)
    );

    for (genvar k = 0; k < NUM_BANKS; k++) begin : g_lane
        rstbank_lane u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .load_en   (bank_we[k] & is_open),
            .load_bits (bus_wdata[BANK_W-1:0]),
            .pulse     (lane_pulse[k])
        );
    end

    assign periph_rst = lane_pulse;

    // Select the running pulses of the addressed bank, or the lock state.
    always_comb begin
        bus_rdata = '0;
        for (int k = 0; k < NUM_BANKS; k++)
            if (bank_hit[k])
                bus_rdata = DATA_W'(lane_pulse[k]);
        if (key_hit)
            bus_rdata = DATA_W'(is_open);
    end

    a_r4_closed_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && !is_open) |=> ((periph_rst & ~$past(periph_rst)) == '0));
endmodule

// File: tb/periph_reset_bank_tb.sv
`timescale 1ns/1ps
module periph_reset_bank_tb_top;
    localparam logic [31:0] KEY  = 32'hA6382D4C;
    localparam logic [31:0] SHUT = 32'hA6382D4D;

    typedef struct packed {
        logic        open_first;
        logic [2:0]  bank;
        logic [31:0] mask;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{1'b1, 3'd0, 32'h0000_0001},
        '{1'b0, 3'd1, 32'hFFFF_FFFF},
        '{1'b1, 3'd4, 32'h8000_0001},
        '{1'b1, 3'd2, 32'hA5A5_5A5A},
        '{1'b0, 3'd3, 32'h1234_5678},
        '{1'b1, 3'd3, 32'hFFFF_FFFF}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [7:0]   bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic         bus_we = 1'b0;
    logic [31:0]  bus_rdata;
    logic [159:0] periph_rst;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    periph_reset_bank dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .periph_rst(periph_rst)
    );

    task automatic check(input string req, input logic [159:0] act, input logic [159:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk);
        #1 bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        logic [159:0] one;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 outputs", periph_rst, '0);
        rd(8'h84, r); check("R1 key read", 160'(r), '0);
        rd(8'h70, r); check("R1 req read", 160'(r), '0);

        // Table walk: R2 R4 R5 R8 across banks and masks
        foreach (VECS[v]) begin
            logic [159:0] exp;
            if (VECS[v].open_first) wr(8'h84, KEY);
            wr(8'h70 + 8'(VECS[v].bank) * 8'd4, VECS[v].mask);
            exp = VECS[v].open_first ? (160'(VECS[v].mask) << (32 * VECS[v].bank)) : '0;
            @(negedge clk);
            check(VECS[v].open_first ? "R5 pulse start" : "R4 closed write", periph_rst, exp);
            rd(8'h70 + 8'(VECS[v].bank) * 8'd4, r);
            check("R8 read running", 160'(r), 160'(exp >> (32 * VECS[v].bank)));
            wr(8'h84, SHUT);
            repeat (6) @(negedge clk);
            check("R6 self clear", periph_rst, '0);
        end

        // R6: exact length
        one = 160'(1) << (32 + 5);
        wr(8'h84, KEY);
        wr(8'h74, 32'h20);
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            check("R6 high cycle", periph_rst, one);
        end
        @(negedge clk);
        check("R6 low after length", periph_rst, '0);

        // R7: restart while running
        wr(8'h74, 32'h20);
        @(negedge clk);
        wr(8'h74, 32'h20);
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            check("R7 restarted high", periph_rst, one);
        end
        @(negedge clk);
        check("R7 low after restart", periph_rst, '0);

        // R9: still open after several request writes
        wr(8'h70, 32'h1);
        wr(8'h80, 32'h4);
        @(negedge clk);
        check("R9 open persists", periph_rst[159:128], 160'(32'h4));
        rd(8'h84, r); check("R2 key read open", 160'(r), 160'(1));

        // R8: unknown address write leaves state
        wr(8'h88, 32'h0);
        rd(8'h84, r); check("R8 stray write keeps open", 160'(r), 160'(1));
        rd(8'h6C, r); check("R8 stray read zero", 160'(r), '0);
        wr(8'h6C, 32'hFFFF_FFFF);
        repeat (6) @(negedge clk);
        check("R8 stray no pulse", periph_rst, '0);

        // R3: near-miss keys close
        wr(8'h84, KEY ^ 32'h8000_0000);
        rd(8'h84, r); check("R3 near miss closes", 160'(r), '0);
        wr(8'h78, 32'hFF);
        @(negedge clk);
        check("R4 no pulse after near miss", periph_rst, '0);
        wr(8'h84, KEY);
        wr(8'h84, SHUT);
        rd(8'h84, r); check("R3 lock word closes", 160'(r), '0);
        wr(8'h88, KEY);
        rd(8'h84, r); check("R8 key at wrong address ignored", 160'(r), '0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule